// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds the architectural state of a stack-organised floating-point unit. It has eight 64-bit registers, each with a two-bit tag, and a three-bit top pointer that wraps modulo eight. It also has a control word, a status word and one scratch register that carries a memory operand into a compare. It carries no arithmetic. It keeps the stack in order, resolves stack-relative indices into physical registers, and produces the condition codes that a compare or an examine reports. Compare results come from the raw IEEE double bit patterns.

A sequencer drives one command per cycle on a valid/ready handshake. The effect of an accepted command can be seen on the outputs from the next cycle on. A peek port gives a stack-relative view of any entry or of the scratch register at any time. The status word output always shows the live top pointer in bits 13:11.

Top module: `fstk_core`

## Requirements
- R1: `cmd_ready` is high whenever `rst` is low. A command is accepted when `cmd_valid` and `cmd_ready` are both high, and its effect is visible from the next cycle on. The `cmd_op` codes are 0 idle, 1 initialise, 2 push, 3 pop, 4 exchange, 5 copy, 6 compare, 7 examine, 8 clear-exceptions and 9 load-scratch. Codes 10 to 15, and cycles with `cmd_valid` low, change no state.
- R2: Reset and the initialise command both set the control word to 0x037F, the status word to 0 and the top pointer to 0. They mark all eight stack tags empty (tag code 2'b11) and the scratch tag valid (2'b00). The tag codes are valid 00, zero 01, special 10 and empty 11.
- R3: Push first decrements the top pointer modulo 8, so 0 becomes 7. It then writes `cmd_data` into the new top entry with a valid tag.
- R4: Pop sets the tag of the current top entry to empty and keeps its value. It then increments the top pointer modulo 8, so 7 becomes 0. Push and pop act the same way on a full or an empty stack, and they leave the condition bits unchanged.
- R5: Stack index i (`peek_idx`, `cmd_idx_a`, `cmd_idx_b`) selects physical register (top + i) mod 8. The top pointer is shown in `sw_out[13:11]`.
- R6: Exchange (index `cmd_idx_a`) swaps both the values and the tags of entry 0 and entry i.
- R7: Copy (index `cmd_idx_a`) writes the value and tag of entry 0 into entry i, and entry 0 keeps its contents.
- R8: Compare orders operand A (entry `cmd_idx_a`) against operand B (entry `cmd_idx_b`) by IEEE value, with +0 equal to -0. The codes are: equal gives C3=1 C2=0 C0=0; A less than B gives C3=0 C2=0 C0=1; A greater than B gives all three 0. The bits are C0 = `sw_out[8]`, C1 = bit 9, C2 = bit 10 and C3 = bit 14. Compare leaves C1 unchanged.
- R9: If either compare operand has a tag other than valid or zero, the result is C3=C2=C0=1. With `cmd_use_scr` high, operand B is the scratch register.
- R10: Examine sets C1 to the sign bit of entry 0. An empty entry 0 gives C3=1 C2=0 C0=1. Otherwise a zero magnitude gives C3=1 C2=0 C0=0 and any other value gives C3=0 C2=1 C0=0.
- R11: Clear-exceptions ANDs the stored status word with 0x7F00, so the condition bits C0 to C3 and the top pointer survive.
- R12: Load-scratch writes `cmd_data` and `cmd_tag` into the scratch register (read through `peek_scr`) and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 4 | Command code |
| cmd_idx_a | input | 3 | Stack index i, or compare operand A |
| cmd_idx_b | input | 3 | Compare operand B index |
| cmd_use_scr | input | 1 | Compare operand B is the scratch register |
| cmd_data | input | 64 | Value for push and load-scratch |
| cmd_tag | input | 2 | Tag for load-scratch |
| peek_idx | input | 3 | Stack index to observe |
| peek_scr | input | 1 | Observe the scratch register instead |
| peek_value | output | 64 | Value of the observed entry |
| peek_tag | output | 2 | Tag of the observed entry |
| cw_out | output | 16 | Control word |
| sw_out | output | 16 | Status word with the live top pointer |

## Verification
The bench builds the block with its default eight-entry stack and 64-bit values. This means a few pushes or pops carry the top pointer across both wrap points, and every physical register can be reached through stack indices. With the scratch register of the same width, the scratch tag can be set to zero or special. That exercises both the ordered and the unordered compare paths, together with compares on mixed signs, on two negatives and on +0 against -0.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    localparam int FP_W     = 64;
    localparam int CC0_BIT  = 8;
    localparam int CC1_BIT  = 9;
    localparam int CC2_BIT  = 10;
    localparam int CC3_BIT  = 14;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    typedef enum logic [3:0] {
        OP_IDLE  = 4'd0,
        OP_INIT  = 4'd1,
        OP_PUSH  = 4'd2,
        OP_POP   = 4'd3,
        OP_XCH   = 4'd4,
        OP_CPY   = 4'd5,
        OP_CMP   = 4'd6,
        OP_EXAM  = 4'd7,
        OP_CLEX  = 4'd8,
        OP_LDSCR = 4'd9
    } op_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
        logic c0;
    } cc_t;

    typedef enum logic [1:0] {
        ORD_EQ = 2'd0,
        ORD_LT = 2'd1,
        ORD_GT = 2'd2
    } ord_e;

    function automatic logic fp_mag_zero(input logic [FP_W-1:0] v);
        return v[FP_W-2:0] == '0;
    endfunction

    function automatic logic tag_ordered(input tag_e t);
        return (t == TAG_VALID) || (t == TAG_ZERO);
    endfunction

    // Sign-magnitude ordering of two raw doubles; +0 and -0 are equal.
    function automatic ord_e fp_order(input logic [FP_W-1:0] a,
                                      input logic [FP_W-1:0] b);
        ord_e r;
        if ((fp_mag_zero(a) && fp_mag_zero(b)) || (a == b))
            r = ORD_EQ;
        else if (a[FP_W-1] != b[FP_W-1])
            r = a[FP_W-1] ? ORD_LT : ORD_GT;
        else if (!a[FP_W-1])
            r = (a[FP_W-2:0] < b[FP_W-2:0]) ? ORD_LT : ORD_GT;
        else
            r = (a[FP_W-2:0] > b[FP_W-2:0]) ? ORD_LT : ORD_GT;
        return r;
    endfunction

endpackage

// File: rtl/fstk_regfile.sv
module fstk_regfile
    import fstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            init_i,
    input  logic            we0_i,
    input  logic [AW-1:0]   wa0_i,
    input  logic [FP_W-1:0] wd0_i,
    input  tag_e            wt0_i,
    input  logic            we1_i,
    input  logic [AW-1:0]   wa1_i,
    input  logic [FP_W-1:0] wd1_i,
    input  tag_e            wt1_i,
    input  logic [AW-1:0]   ra_i,
    input  logic [AW-1:0]   rb_i,
    input  logic [AW-1:0]   rp_i,
    output logic [FP_W-1:0] rav_o,
    output tag_e            rat_o,
    output logic [FP_W-1:0] rbv_o,
    output tag_e            rbt_o,
    output logic [FP_W-1:0] rpv_o,
    output tag_e            rpt_o,
    output tag_e            tags_o [DEPTH+1]
);

    logic [FP_W-1:0] ent_val [DEPTH+1];

    // Entry DEPTH is the scratch register; its initial tag is valid.
    for (genvar e = 0; e <= DEPTH; e++) begin : g_ent
        localparam tag_e INIT_TAG = (e == DEPTH) ? TAG_VALID : TAG_EMPTY;
        logic [FP_W-1:0] val_q;
        tag_e            tag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
                tag_q <= INIT_TAG;
            end else if (init_i) begin
                tag_q <= INIT_TAG;
            end else begin
                if (we0_i && wa0_i == AW'(e)) begin
                    val_q <= wd0_i;
                    tag_q <= wt0_i;
                end
                if (we1_i && wa1_i == AW'(e)) begin
                    val_q <= wd1_i;
                    tag_q <= wt1_i;
                end
            end
        end

        assign ent_val[e] = val_q;
        assign tags_o[e]  = tag_q;
    end

    assign rav_o = ent_val[ra_i];
    assign rat_o = tags_o[ra_i];
    assign rbv_o = ent_val[rb_i];
    assign rbt_o = tags_o[rb_i];
    assign rpv_o = ent_val[rp_i];
    assign rpt_o = tags_o[rp_i];

    AST_INIT_SCR_VALID: assert property (@(posedge clk) disable iff (rst)
        init_i |=> tags_o[DEPTH] == TAG_VALID); // R2

    AST_INIT_BOTTOM_EMPTY: assert property (@(posedge clk) disable iff (rst)
        init_i |=> tags_o[0] == TAG_EMPTY); // R2

endmodule

// File: rtl/fstk_cond.sv
module fstk_cond
    import fstk_pkg::*;
(
    input  logic [FP_W-1:0] a_val_i,
    input  tag_e            a_tag_i,
    input  logic [FP_W-1:0] b_val_i,
    input  tag_e            b_tag_i,
    output cc_t             cmp_cc_o,
    output cc_t             exam_cc_o
);

    ord_e ord;

    always_comb begin
        ord      = fp_order(a_val_i, b_val_i);
        cmp_cc_o = '0;
        if (!tag_ordered(a_tag_i) || !tag_ordered(b_tag_i)) begin
            cmp_cc_o.c3 = 1'b1;
            cmp_cc_o.c2 = 1'b1;
            cmp_cc_o.c0 = 1'b1;
        end else begin
            cmp_cc_o.c3 = (ord == ORD_EQ);
            cmp_cc_o.c0 = (ord == ORD_LT);
        end
    end

    always_comb begin
        exam_cc_o    = '0;
        exam_cc_o.c1 = a_val_i[FP_W-1];
        if (a_tag_i == TAG_EMPTY) begin
            exam_cc_o.c3 = 1'b1;
            exam_cc_o.c0 = 1'b1;
        end else if (fp_mag_zero(a_val_i)) begin
            exam_cc_o.c3 = 1'b1;
        end else begin
            exam_cc_o.c2 = 1'b1;
        end
    end

endmodule

// File: rtl/fstk_core.sv
module fstk_core
    import fstk_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter logic [15:0] CW_INIT = 16'h037F,
    parameter logic [15:0] SW_KEEP = 16'h7F00
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [3:0]      cmd_op,
    input  logic [2:0]      cmd_idx_a,
    input  logic [2:0]      cmd_idx_b,
    input  logic            cmd_use_scr,
    input  logic [63:0]     cmd_data,
    input  logic [1:0]      cmd_tag,
    input  logic [2:0]      peek_idx,
    input  logic            peek_scr,
    output logic [63:0]     peek_value,
    output logic [1:0]      peek_tag,
    output logic [15:0]     cw_out,
    output logic [15:0]     sw_out
);

    localparam int PW = $clog2(DEPTH);
    localparam int AW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] SCR_ADDR = AW'(DEPTH);

    function automatic logic [AW-1:0] phys(input logic [PW-1:0] top,
                                           input logic [2:0]    idx);
        logic [PW-1:0] sum;
        sum = top + PW'(idx);
        return AW'(sum);
    endfunction

    logic [PW-1:0]  top_q;
    logic [15:0]    cw_q;
    logic [1:0]     sw_hi_q;
    logic [10:0]    sw_lo_q;

    logic           fire;
    op_e            op;
    logic [AW-1:0]  ra, rb, rp;
    logic [FP_W-1:0] rav, rbv, rpv;
    tag_e           rat, rbt, rpt;
    tag_e           tags [DEPTH+1];
    logic           we0, we1, init_s;
    logic [AW-1:0]  wa0, wa1;
    logic [FP_W-1:0] wd0, wd1;
    tag_e           wt0, wt1;
    cc_t            cmp_cc, exam_cc;
    logic [PW-1:0]  top_dn, top_up;

    assign cmd_ready = !rst;
    assign fire      = cmd_valid && cmd_ready;
    assign op        = op_e'(cmd_op);
    assign top_dn    = top_q - 1'b1;
    assign top_up    = top_q + 1'b1;

    assign ra = (op == OP_CMP) ? phys(top_q, cmd_idx_a) : AW'(top_q);
    assign rb = (op == OP_CMP) ? (cmd_use_scr ? SCR_ADDR : phys(top_q, cmd_idx_b))
                               : phys(top_q, cmd_idx_a);
    assign rp = peek_scr ? SCR_ADDR : phys(top_q, peek_idx);

    always_comb begin
        init_s = fire && (op == OP_INIT);
        we0 = 1'b0;  wa0 = AW'(top_q);  wd0 = rav;  wt0 = rat;
        we1 = 1'b0;  wa1 = rb;          wd1 = rav;  wt1 = rat;
        if (fire) begin
            unique case (op)
                OP_PUSH: begin
                    we0 = 1'b1;  wa0 = AW'(top_dn);
                    wd0 = cmd_data;  wt0 = TAG_VALID;
                end
                OP_POP: begin
                    we0 = 1'b1;  wt0 = TAG_EMPTY;
                end
                OP_XCH: begin
                    we0 = 1'b1;  wd0 = rbv;  wt0 = rbt;
                    we1 = 1'b1;
                end
                OP_CPY: begin
                    we1 = 1'b1;
                end
                OP_LDSCR: begin
                    we0 = 1'b1;  wa0 = SCR_ADDR;
                    wd0 = cmd_data;  wt0 = tag_e'(cmd_tag);
                end
                default: ;
            endcase
        end
    end

    fstk_regfile #(.DEPTH(DEPTH)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_s),
        .we0_i  (we0), .wa0_i (wa0), .wd0_i (wd0), .wt0_i (wt0),
        .we1_i  (we1), .wa1_i (wa1), .wd1_i (wd1), .wt1_i (wt1),
        .ra_i   (ra),  .rb_i  (rb),  .rp_i  (rp),
        .rav_o  (rav), .rat_o (rat),
        .rbv_o  (rbv), .rbt_o (rbt),
        .rpv_o  (rpv), .rpt_o (rpt),
        .tags_o (tags)
    );

    fstk_cond i_cond (
        .a_val_i   (rav),
        .a_tag_i   (rat),
        .b_val_i   (rbv),
        .b_tag_i   (rbt),
        .cmp_cc_o  (cmp_cc),
        .exam_cc_o (exam_cc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q   <= '0;
            cw_q    <= CW_INIT;
            sw_hi_q <= '0;
            sw_lo_q <= '0;
        end else if (fire) begin
            unique case (op)
                OP_INIT: begin
                    top_q   <= '0;
                    cw_q    <= CW_INIT;
                    sw_hi_q <= '0;
                    sw_lo_q <= '0;
                end
                OP_PUSH: top_q <= top_dn;
                OP_POP:  top_q <= top_up;
                OP_CMP: begin
                    sw_hi_q[CC3_BIT-14] <= cmp_cc.c3;
                    sw_lo_q[CC2_BIT]    <= cmp_cc.c2;
                    sw_lo_q[CC0_BIT]    <= cmp_cc.c0;
                end
                OP_EXAM: begin
                    sw_hi_q[CC3_BIT-14] <= exam_cc.c3;
                    sw_lo_q[CC2_BIT]    <= exam_cc.c2;
                    sw_lo_q[CC1_BIT]    <= exam_cc.c1;
                    sw_lo_q[CC0_BIT]    <= exam_cc.c0;
                end
                OP_CLEX: begin
                    sw_hi_q <= sw_hi_q & SW_KEEP[15:14];
                    sw_lo_q <= sw_lo_q & SW_KEEP[10:0];
                end
                default: ;
            endcase
        end
    end

    assign cw_out     = cw_q;
    assign sw_out     = {sw_hi_q, 3'(top_q), sw_lo_q};
    assign peek_value = rpv;
    assign peek_tag   = rpt;

    AST_PUSH_TOP_DEC: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_PUSH) |=> top_q == PW'($past(top_q) - 1'b1)); // R3

    AST_POP_MARKS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_POP) |=> tags[$past(top_q)] == TAG_EMPTY); // R4

    AST_INIT_WORDS: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_INIT) |=> (cw_out == CW_INIT && sw_out == 16'h0000)); // R2

    AST_UNORDERED_CODE: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_CMP && (!tag_ordered(rat) || !tag_ordered(rbt)))
        |=> (sw_out[CC3_BIT] && sw_out[CC2_BIT] && sw_out[CC0_BIT])); // R9

    AST_EXAM_SIGN: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_EXAM) |=> sw_out[CC1_BIT] == $past(rav[FP_W-1])); // R10

    AST_CMP_C1_KEPT: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_CMP) |=> $stable(sw_out[CC1_BIT])); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(sw_out) && $stable(cw_out))); // R1

endmodule

// File: tb/test_fstk_core.sv
module test_fstk_core;

    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] D_TWO  = 64'h4000000000000000;
    localparam logic [63:0] D_M3   = 64'hC008000000000000;
    localparam logic [63:0] D_M4   = 64'hC010000000000000;
    localparam logic [63:0] D_M5   = 64'hC014000000000000;
    localparam logic [63:0] D_PZ   = 64'h0000000000000000;
    localparam logic [63:0] D_NZ   = 64'h8000000000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_op = '0;
    logic [2:0]  cmd_idx_a = '0;
    logic [2:0]  cmd_idx_b = '0;
    logic        cmd_use_scr = 1'b0;
    logic [63:0] cmd_data = '0;
    logic [1:0]  cmd_tag = '0;
    logic [2:0]  peek_idx = '0;
    logic        peek_scr = 1'b0;
    logic [63:0] peek_value;
    logic [1:0]  peek_tag;
    logic [15:0] cw_out;
    logic [15:0] sw_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fstk_core i_fstk_core (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_idx_a(cmd_idx_a), .cmd_idx_b(cmd_idx_b), .cmd_use_scr(cmd_use_scr),
        .cmd_data(cmd_data), .cmd_tag(cmd_tag),
        .peek_idx(peek_idx), .peek_scr(peek_scr),
        .peek_value(peek_value), .peek_tag(peek_tag),
        .cw_out(cw_out), .sw_out(sw_out)
    );

    function automatic logic [15:0] swx(input int top, input logic c3,
                                        input logic c2, input logic c1,
                                        input logic c0);
        return {1'b0, c3, 3'(top), c2, c1, c0, 8'h00};
    endfunction

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input int op, input int ia = 0, input int ib = 0,
                       input logic scr = 1'b0, input logic [63:0] d = '0,
                       input logic [1:0] t = 2'b00);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_idx_a = 3'(ia);
        cmd_idx_b = 3'(ib); cmd_use_scr = scr; cmd_data = d; cmd_tag = t;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic peek(input int idx, input logic scr,
                        output logic [63:0] v, output logic [1:0] t);
        peek_idx = 3'(idx); peek_scr = scr;
        #1;
        v = peek_value; t = peek_tag;
    endtask

    task automatic t_reset;
        logic [63:0] v; logic [1:0] t;
        chk("R1 ready", 64'(cmd_ready), 64'd1);
        chk("R2 cw", 64'(cw_out), 64'h037F);
        chk("R2 sw", 64'(sw_out), 64'h0);
        for (int i = 0; i < 8; i++) begin
            peek(i, 1'b0, v, t);
            chk("R2 tag empty", 64'(t), 64'd3);
        end
        peek(0, 1'b1, v, t);
        chk("R2 scratch tag", 64'(t), 64'd0);
    endtask

    task automatic t_push_pop;
        logic [63:0] v; logic [1:0] t;
        cmd(2, 0, 0, 1'b0, D_ONE);
        chk("R3 top wraps to 7", 64'(sw_out), 64'(swx(7, 0, 0, 0, 0)));
        peek(0, 1'b0, v, t);
        chk("R3 value", v, D_ONE);
        chk("R3 tag", 64'(t), 64'd0);
        cmd(2, 0, 0, 1'b0, D_TWO);
        peek(0, 1'b0, v, t);
        chk("R5 st0", v, D_TWO);
        peek(1, 1'b0, v, t);
        chk("R5 st1", v, D_ONE);
        cmd(3);
        chk("R4 top inc", 64'(sw_out), 64'(swx(7, 0, 0, 0, 0)));
        peek(7, 1'b0, v, t);
        chk("R4 popped tag empty", 64'(t), 64'd3);
        chk("R4 popped value kept", v, D_TWO);
        cmd(3);
        chk("R4 top wraps to 0", 64'(sw_out), 64'(swx(0, 0, 0, 0, 0)));
        cmd(3);
        chk("R4 pop on empty no fault", 64'(sw_out), 64'(swx(1, 0, 0, 0, 0)));
        cmd(12, 2, 0, 1'b0, D_M5);
        chk("R1 unknown op sw", 64'(sw_out), 64'(swx(1, 0, 0, 0, 0)));
        peek(0, 1'b1, v, t);
        chk("R1 unknown op scratch", v, D_PZ);
        @(negedge clk);
        cmd_op = 4'd2; cmd_data = D_M5;
        @(negedge clk);
        cmd_op = '0;
        chk("R1 no valid no push", 64'(sw_out), 64'(swx(1, 0, 0, 0, 0)));
    endtask

    task automatic t_xch_cpy;
        logic [63:0] v; logic [1:0] t;
        cmd(1);
        cmd(2, 0, 0, 1'b0, D_ONE);
        cmd(2, 0, 0, 1'b0, D_TWO);
        cmd(2, 0, 0, 1'b0, D_M3);
        cmd(4, 2);
        peek(0, 1'b0, v, t);
        chk("R6 st0 value", v, D_ONE);
        peek(2, 1'b0, v, t);
        chk("R6 st2 value", v, D_M3);
        cmd(4, 3);
        peek(0, 1'b0, v, t);
        chk("R6 st0 tag from empty", 64'(t), 64'd3);
        peek(3, 1'b0, v, t);
        chk("R6 st3 value", v, D_ONE);
        chk("R6 st3 tag", 64'(t), 64'd0);
        cmd(4, 3);
        cmd(5, 4);
        peek(4, 1'b0, v, t);
        chk("R7 copy value", v, D_ONE);
        chk("R7 copy tag", 64'(t), 64'd0);
        peek(0, 1'b0, v, t);
        chk("R7 source kept", v, D_ONE);
    endtask

    task automatic t_compare;
        cmd(1);
        cmd(2, 0, 0, 1'b0, D_TWO);
        cmd(2, 0, 0, 1'b0, D_ONE);
        cmd(6, 0, 1);
        chk("R8 less", 64'(sw_out), 64'(swx(6, 0, 0, 0, 1)));
        cmd(6, 1, 0);
        chk("R8 greater", 64'(sw_out), 64'(swx(6, 0, 0, 0, 0)));
        cmd(6, 0, 0);
        chk("R8 equal", 64'(sw_out), 64'(swx(6, 1, 0, 0, 0)));
        cmd(2, 0, 0, 1'b0, D_M4);
        cmd(6, 0, 1);
        chk("R8 mixed sign less", 64'(sw_out), 64'(swx(5, 0, 0, 0, 1)));
        cmd(2, 0, 0, 1'b0, D_M5);
        cmd(6, 1, 0);
        chk("R8 negatives greater", 64'(sw_out), 64'(swx(4, 0, 0, 0, 0)));
        cmd(6, 0, 4);
        chk("R9 empty operand", 64'(sw_out), 64'(swx(4, 1, 1, 0, 1)));
        cmd(2, 0, 0, 1'b0, D_NZ);
        cmd(9, 0, 0, 1'b0, D_PZ, 2'b01);
        cmd(6, 0, 0, 1'b1);
        chk("R8 minus zero equals zero", 64'(sw_out), 64'(swx(3, 1, 0, 0, 0)));
        cmd(9, 0, 0, 1'b0, D_ONE, 2'b10);
        cmd(6, 0, 0, 1'b1);
        chk("R9 special scratch", 64'(sw_out), 64'(swx(3, 1, 1, 0, 1)));
    endtask

    task automatic t_examine;
        logic [63:0] v; logic [1:0] t;
        cmd(7);
        chk("R10 negative zero", 64'(sw_out), 64'(swx(3, 1, 0, 1, 0)));
        cmd(6, 0, 1);
        chk("R8 C1 kept", 64'(sw_out[9]), 64'd1);
        cmd(3);
        cmd(7);
        chk("R10 nonzero", 64'(sw_out), 64'(swx(4, 0, 1, 1, 0)));
        cmd(8);
        chk("R11 clear keeps codes", 64'(sw_out), 64'(swx(4, 0, 1, 1, 0)));
        cmd(1);
        cmd(2, 0, 0, 1'b0, D_TWO);
        cmd(3);
        cmd(7);
        chk("R10 empty", 64'(sw_out), 64'(swx(0, 1, 0, 0, 1)));
        cmd(9, 0, 0, 1'b0, D_M3, 2'b10);
        peek(0, 1'b1, v, t);
        chk("R12 scratch value", v, D_M3);
        chk("R12 scratch tag", 64'(t), 64'd2);
        peek(0, 1'b0, v, t);
        chk("R12 stack untouched", 64'(t), 64'd3);
        cmd(1);
        chk("R2 init cw", 64'(cw_out), 64'h037F);
        chk("R2 init sw", 64'(sw_out), 64'h0);
        peek(0, 1'b1, v, t);
        chk("R2 init scratch valid", 64'(t), 64'd0);
        peek(7, 1'b0, v, t);
        chk("R2 init tags empty", 64'(t), 64'd3);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_push_pop;
        t_xch_cpy;
        t_compare;
        t_examine;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule